// File: doc/BRIEF.md
# Overcurrent Fault Timer

This block is the digital half of an overcurrent protector that sits behind two analog comparators. A breaker comparator reports a moderate overcurrent. The block trips on it only when the condition lasts for a programmable filter time, so short spikes pass without effect. A quick-trip comparator reports a severe overcurrent. It forces the gate off in the same cycle, with no filtering, and it also latches the fault.

Both trip paths feed one fault latch, which drives an active-low fault flag and holds the power switch off. A mode input chooses what happens after a trip:

- In latched mode the block stays off until the active-low clear input is pulsed.
- In retry mode a cool-down timer runs from the most recent trip. When it expires, the timer releases the fault and sends a one-cycle restart request to the power sequencer.

A status output reports whether the latest trip came from the quick path or the filtered path.

The inputs are assumed to be synchronous to the clock. The filter and cool-down lengths are set as cycle counts.

Top module: `ocp_fault_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, all state clears. After reset, `fault_n` is 1, `restart_req` is 0 and `trip_quick` is 0. With `clr_n` high and `qt_in` low, `gate_kill` is 0.
- R2: If `cb_in` is sampled high on FILT_CYCLES consecutive edges, the fault latches on the last of those edges. `fault_n` reads 0 after that edge and not before it.
- R3: A `cb_in` pulse shorter than FILT_CYCLES sampled edges never latches a fault. The run count restarts whenever `cb_in` is sampled low, so two short pulses separated by a low cycle do not add up.
- R4: `qt_in` high drives `gate_kill` high in the same cycle, with no clock edge needed. The fault latches at the next edge.
- R5: With `mode_retry` = 0, a latched fault stays set for as long as `clr_n` stays high, and `restart_req` stays 0.
- R6: `clr_n` low drives `gate_kill` high at once. At each edge where `clr_n` is low, the fault and `trip_quick` are cleared, and any trip on either input is ignored.
- R7: With `mode_retry` = 1, a fault latched at edge t is released at edge t+COOL_CYCLES. `fault_n` returns to 1 and `restart_req` is 1 for exactly the one cycle after that edge.
- R8: With `mode_retry` = 1, a new trip during the cool-down restarts the timer. The fault is released COOL_CYCLES edges after the latest trip.
- R9: `trip_quick` is set to 1 by a quick trip and to 0 by a filtered trip. If both paths trip on the same edge, quick wins.
- R10: While the fault is latched (`fault_n` = 0), `gate_kill` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cb_in | input | 1 | Breaker comparator output, high on overcurrent |
| qt_in | input | 1 | Quick-trip comparator output, high on severe overcurrent |
| mode_retry | input | 1 | 0 = latch off after a trip, 1 = timed retry |
| clr_n | input | 1 | Active-low fault clear and forced off |
| gate_kill | output | 1 | High turns the power switch and the converter enables off |
| fault_n | output | 1 | Active-low latched fault flag |
| restart_req | output | 1 | One-cycle restart request at the end of the cool-down |
| trip_quick | output | 1 | Source of the latest trip: 1 quick, 0 filtered |

## Verification
Breaker pulses of every length from one cycle to twice the filter time are applied, and the flag is checked on every cycle. This separates an off-by-one in the filter window from a correct trip edge. A split pulse (three high, one low, three high) shows that the run count really restarts instead of accumulating. In retry mode the output is traced cycle by cycle through the cool-down, and a second trip is injected at every offset inside it. This tells a timer that restarts apart from one that keeps running or that ignores the new trip. Quick, filtered and simultaneous trips, each followed by a clear, confirm the source bit and the immediate kill.

// File: rtl/ocp_pkg.sv
// Package: ocp_pkg
// Shared types for the overcurrent fault timer.
package ocp_pkg;
    // Which path caused the most recent trip
    typedef enum logic [1:0] {
        TRIP_NONE     = 2'd0,
        TRIP_FILTERED = 2'd1,
        TRIP_QUICK    = 2'd2
    } trip_src_t;
endpackage

// File: rtl/ocp_glitch_filter.sv
// Module: ocp_glitch_filter
// Counts consecutive high samples of the breaker comparator and raises
// a trip once FILT_CYCLES of them have been seen. Any low sample, or a
// clear, restarts the count. Assumes cb_in is already synchronous.
module ocp_glitch_filter #(
    parameter int FILT_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cb_in,
    input  logic clr_n,
    output logic cb_trip
);
    localparam int CW = (FILT_CYCLES > 2) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] run_q;

    // Trip on the sample that completes the window
    assign cb_trip = cb_in && clr_n && (run_q == LAST);

    // Count consecutive highs, saturating at the window end
    always_ff @(posedge clk) begin
        if (!rst_n || !cb_in || !clr_n) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/ocp_cooldown.sv
// Module: ocp_cooldown
// Retry cool-down timer. It runs while a fault is held in retry mode,
// restarts from zero on every new trip, and flags expiry on the
// COOL_CYCLES-th edge after the latest trip.
module ocp_cooldown #(
    parameter int COOL_CYCLES = 675_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic retrig,
    output logic expire
);
    localparam int CW = (COOL_CYCLES > 2) ? $clog2(COOL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(COOL_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Expiry only when running and no trip lands in the same cycle
    assign expire = run && !retrig && (cnt_q == LAST);

    // Advance while running; zero on trip, on stop and on expiry
    always_ff @(posedge clk) begin
        if (!rst_n || !run || retrig || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ocp_fault_latch.sv
// Module: ocp_fault_latch
// Holds the fault state, the source of the latest trip and the restart
// pulse. Clear has priority over a trip, and a trip has priority over
// expiry of the cool-down.
module ocp_fault_latch
    import ocp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cb_trip,
    input  logic      qt_in,
    input  logic      clr_n,
    input  logic      expire,
    output logic      fault,
    output logic      restart_req,
    output trip_src_t src
);
    logic trip;

    assign trip = cb_trip || qt_in;

    // Fault state: set by either trip, cleared by clear or cool-down expiry
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            fault <= 1'b0;
        end else if (trip) begin
            fault <= 1'b1;
        end else if (expire) begin
            fault <= 1'b0;
        end
    end

    // Record the trip source, quick path first
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) begin
            src <= TRIP_NONE;
        end else if (qt_in) begin
            src <= TRIP_QUICK;
        end else if (cb_trip) begin
            src <= TRIP_FILTERED;
        end
    end

    // One-cycle restart request on release by the timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_req <= 1'b0;
        end else begin
            restart_req <= clr_n && expire && !trip;
        end
    end
endmodule

// File: rtl/ocp_fault_timer.sv
// Module: ocp_fault_timer
// Overcurrent fault timer top. It combines a filtered breaker trip and
// an unfiltered quick trip into one fault latch, with either latch-off
// or timed-retry recovery. The kill output is combinational on the
// quick-trip and clear inputs so that both act without a clock edge.
// Assumes all inputs are synchronous to clk.
module ocp_fault_timer
    import ocp_pkg::*;
#(
    parameter int FILT_CYCLES = 5000,
    parameter int COOL_CYCLES = 675_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cb_in,
    input  logic qt_in,
    input  logic mode_retry,
    input  logic clr_n,
    output logic gate_kill,
    output logic fault_n,
    output logic restart_req,
    output logic trip_quick
);
    logic      cb_trip;
    logic      expire;
    logic      fault;
    trip_src_t src;

    ocp_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cb_in   (cb_in),
        .clr_n   (clr_n),
        .cb_trip (cb_trip)
    );

    ocp_cooldown #(.COOL_CYCLES(COOL_CYCLES)) u_cool (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (fault && mode_retry && clr_n),
        .retrig (cb_trip || qt_in),
        .expire (expire)
    );

    ocp_fault_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cb_trip     (cb_trip),
        .qt_in       (qt_in),
        .clr_n       (clr_n),
        .expire      (expire),
        .fault       (fault),
        .restart_req (restart_req),
        .src         (src)
    );

    // Immediate kill paths plus the held fault
    assign gate_kill  = fault || qt_in || !clr_n;
    assign fault_n    = !fault;
    assign trip_quick = (src == TRIP_QUICK);
endmodule

// File: rtl/ocp_fault_timer_chk.sv
// Module: ocp_fault_timer_chk
// Port-level checker for ocp_fault_timer, attached by bind below.
// It keeps its own run count of breaker samples to bound the filter window.
module ocp_fault_timer_chk #(
    parameter int FILT_CYCLES = 5000,
    parameter int COOL_CYCLES = 675_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic cb_in,
    input logic qt_in,
    input logic mode_retry,
    input logic clr_n,
    input logic gate_kill,
    input logic fault_n,
    input logic restart_req,
    input logic trip_quick
);
    int cb_run;
    logic cool_ok;

    assign cool_ok = (COOL_CYCLES >= 1);

    // Consecutive high breaker samples seen before this cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !cb_in || !clr_n) begin
            cb_run <= 0;
        end else if (cb_run < FILT_CYCLES - 1) begin
            cb_run <= cb_run + 1;
        end
    end

    a_r3_short_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n && clr_n && !qt_in && !(cb_in && cb_run >= FILT_CYCLES - 1)) |=> fault_n);

    a_r4_quick_kill: assert property (@(posedge clk) disable iff (!rst_n)
        qt_in |-> gate_kill);

    a_r4_quick_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (qt_in && clr_n) |=> !fault_n);

    a_r5_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && clr_n && !mode_retry) |=> (!fault_n && !restart_req));

    a_r6_clear_kill: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> gate_kill);

    a_r6_clear_release: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (fault_n && !trip_quick && !restart_req));

    a_r7_restart_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> (cool_ok && fault_n && $past(!fault_n) && $past(mode_retry)));

    a_r9_quick_source: assert property (@(posedge clk) disable iff (!rst_n)
        (qt_in && clr_n) |=> trip_quick);

    a_r10_fault_kills: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> gate_kill);
endmodule

bind ocp_fault_timer ocp_fault_timer_chk #(
    .FILT_CYCLES(FILT_CYCLES),
    .COOL_CYCLES(COOL_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cb_in       (cb_in),
    .qt_in       (qt_in),
    .mode_retry  (mode_retry),
    .clr_n       (clr_n),
    .gate_kill   (gate_kill),
    .fault_n     (fault_n),
    .restart_req (restart_req),
    .trip_quick  (trip_quick)
);

// File: tb/test_ocp_fault_timer.sv
`timescale 1ns/1ps
module test_ocp_fault_timer;
    localparam int FILT = 4;
    localparam int COOL = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cb_in = 1'b0;
    logic qt_in = 1'b0;
    logic mode_retry = 1'b0;
    logic clr_n = 1'b1;
    logic gate_kill, fault_n, restart_req, trip_quick;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    ocp_fault_timer #(.FILT_CYCLES(FILT), .COOL_CYCLES(COOL)) i_ocp_fault_timer (
        .clk(clk), .rst_n(rst_n), .cb_in(cb_in), .qt_in(qt_in),
        .mode_retry(mode_retry), .clr_n(clr_n), .gate_kill(gate_kill),
        .fault_n(fault_n), .restart_req(restart_req), .trip_quick(trip_quick)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Pulse clr_n for one edge; checks R6 immediate kill and release
    task automatic do_clear();
        clr_n = 1'b0;
        #1;
        chk("R6", "gate_kill during clear", gate_kill, 1'b1);
        @(negedge clk);
        chk("R6", "fault_n after clear", fault_n, 1'b1);
        chk("R6", "trip_quick after clear", trip_quick, 1'b0);
        clr_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "fault_n", fault_n, 1'b1);
        chk("R1", "gate_kill", gate_kill, 1'b0);
        chk("R1", "restart_req", restart_req, 1'b0);
        chk("R1", "trip_quick", trip_quick, 1'b0);

        // R2 / R3 / R5: breaker pulse lengths 1..2*FILT in latched mode
        for (int len = 1; len <= 2 * FILT; len++) begin
            cb_in = 1'b1;
            for (int j = 1; j <= len; j++) begin
                @(negedge clk);
                chk((j >= FILT) ? "R2" : "R3", "fault_n during pulse", fault_n, !(j >= FILT));
            end
            cb_in = 1'b0;
            repeat (5) @(negedge clk);
            chk("R5", "fault_n after pulse", fault_n, !(len >= FILT));
            chk("R5", "restart_req latched", restart_req, 1'b0);
            if (len >= FILT) begin
                chk("R9", "filtered source", trip_quick, 1'b0);
                chk("R10", "gate_kill held", gate_kill, 1'b1);
            end else begin
                chk("R3", "gate_kill idle", gate_kill, 1'b0);
            end
            do_clear();
        end

        // R3: split pulse (FILT-1 high, 1 low, FILT-1 high) never trips
        for (int p = 0; p < 2; p++) begin
            cb_in = 1'b1;
            repeat (FILT - 1) @(negedge clk);
            cb_in = 1'b0;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk("R3", "split pulse ignored", fault_n, 1'b1);

        // R4 / R9: quick trip, immediate kill, then latched hold (R5)
        qt_in = 1'b1;
        #1;
        chk("R4", "immediate gate_kill", gate_kill, 1'b1);
        chk("R4", "not yet latched", fault_n, 1'b1);
        @(negedge clk);
        qt_in = 1'b0;
        chk("R4", "latched after edge", fault_n, 1'b0);
        chk("R9", "quick source", trip_quick, 1'b1);
        repeat (3 * COOL) @(negedge clk);
        chk("R5", "long hold", fault_n, 1'b0);
        chk("R5", "no restart", restart_req, 1'b0);
        do_clear();

        // R9: both paths on the same edge -> quick wins
        cb_in = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        qt_in = 1'b1;
        @(negedge clk);
        cb_in = 1'b0;
        qt_in = 1'b0;
        chk("R9", "simultaneous source", trip_quick, 1'b1);
        do_clear();

        // R6: trips ignored while clear held low
        clr_n = 1'b0;
        qt_in = 1'b1;
        cb_in = 1'b1;
        repeat (FILT + 2) @(negedge clk);
        chk("R6", "trip ignored in clear", fault_n, 1'b1);
        chk("R6", "kill during clear", gate_kill, 1'b1);
        qt_in = 1'b0;
        cb_in = 1'b0;
        clr_n = 1'b1;
        @(negedge clk);
        chk("R6", "released", gate_kill, 1'b0);

        // R7: filtered trip in retry mode, trace cool-down per cycle
        mode_retry = 1'b1;
        cb_in = 1'b1;
        repeat (FILT) @(negedge clk);
        cb_in = 1'b0;
        for (int k = 0; k <= COOL + 2; k++) begin
            chk("R7", "fault_n in cool-down", fault_n, !(k < COOL));
            chk("R7", "restart pulse", restart_req, (k == COOL));
            @(negedge clk);
        end

        // R8: retrigger with a quick trip at every offset inside cool-down
        for (int off = 1; off < COOL; off++) begin
            qt_in = 1'b1;
            @(negedge clk);
            for (int k = 0; k <= off + COOL + 1; k++) begin
                chk("R8", "fault_n after retrigger", fault_n, !(k < off + COOL));
                chk("R8", "restart after retrigger", restart_req, (k == off + COOL));
                qt_in = (k + 1 == off);
                @(negedge clk);
            end
            qt_in = 1'b0;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule